// File: doc/BRIEF.md
# Universal Timer With Prescaler

A general-purpose 16-bit timer that counts edges of a separate timer clock signal, sampled in the system clock domain. The active edge of that timer clock can be chosen. A programmable prescaler divides the selected edges by any ratio from 1 to 256. The count is compared against a period value held in a shadowed register, so software may write a new period at any time without disturbing the period in progress.

When the count reaches the period, the timer does one of three things: it wraps to zero, it freezes at the period value (limit mode), or it keeps counting (free mode). Optionally it also stops itself (one-shot). A period match raises a sticky period flag. It also drives either a level output that follows the run state or a pulse one timer clock long. A single external input, after polarity inversion, provides capture events next to a capture command. Each capture copies the live count into one capture register and raises a sticky capture flag. A clear command zeroes the count at once.

A parameter adds a two-flop synchronizer stage on the incoming commands and on the outgoing run and output status.

Top module: `univ_timer`

## Requirements
- R1: A prescaler select value n (0..255) gives one count step for every n+1 selected timer clock edges, counted from the start of the timer or from the last clear.
- R2: With `tclk_rise` = 0 only falling edges of `tclk_in` are counted; with `tclk_rise` = 1 only rising edges are counted.
- R3: A period write lands in a shadow register. The active period takes the shadow value only at a period match while `wrap_en` = 1, or when `start` arrives while the timer is stopped.
- R4: A period match is a count step taken while the count equals the active period. With `wrap_en` = 1, the count returns to 0 at a period match.
- R5: With `wrap_en` = 0 and `limit_en` = 1, the count stays at the period value once it gets there, while `run` and the level output remain 1.
- R6: With `wrap_en` = 0 and `limit_en` = 0, the count passes the period value and keeps incrementing.
- R7: `clr_cmd` sets the count to 0 on the next cycle and restarts the prescaler. It takes precedence over a count step in the same cycle.
- R8: A capture event is `capt_cmd`, or a 0-to-1 change of `ext_in` XOR `ext_pol`. It loads the count held before that cycle's update into `capture` and sets `cap_flag`.
- R9: With `oneshot_en` = 1, a period match clears `run`.
- R10: With `pulse_mode` = 0, `tout` equals `run`. With `pulse_mode` = 1, `tout` goes to 1 at a period match and returns to 0 at the next selected timer clock edge that is not itself a match.
- R11: `prd_flag` sets at every period match. Both flags stay set until cleared by `flag_clr` (bit 0 clears `prd_flag`, bit 1 clears `cap_flag`); a set in the same cycle wins over the clear.
- R12: `start` sets `run` and `stop` clears it, with `stop` winning. While stopped, the count holds and the prescaler stays at its start position.
- R13: After reset, `count`, `capture`, `run`, `tout`, `prd_flag` and `cap_flag` are 0 and the active and shadow periods hold all ones.
- R14: With `SYNC_EN` = 1, a `start` shows on `run` five cycles after it is sampled, against one cycle without the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tclk_in | input | 1 | Timer clock signal, sampled by clk |
| tclk_rise | input | 1 | Active edge select: 1 rising, 0 falling |
| psel | input | 8 | Prescaler select, divide by psel+1 |
| start | input | 1 | Start strobe |
| stop | input | 1 | Stop strobe |
| oneshot_en | input | 1 | Stop at the first period match |
| wrap_en | input | 1 | Reset count to 0 at period match |
| limit_en | input | 1 | Freeze count at period when not wrapping |
| pulse_mode | input | 1 | Output mode: 1 pulse, 0 level |
| per_wr | input | 1 | Write strobe for the shadow period |
| per_wdata | input | 16 | New period value |
| ext_in | input | 1 | External capture input |
| ext_pol | input | 1 | Inverts ext_in before edge detection |
| clr_cmd | input | 1 | Clear-count command |
| capt_cmd | input | 1 | Capture command |
| flag_clr | input | 2 | Flag clear: bit 0 period, bit 1 capture |
| count | output | 16 | Live count |
| capture | output | 16 | Captured count |
| run | output | 1 | Timer running status |
| tout | output | 1 | Level or pulse output |
| prd_flag | output | 1 | Sticky period-match flag |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The hardest state to reach is a rewritten shadow period coinciding with a wrap. The write must be pending while the count sits one step short of the old period, and a prescaled step must then fall on the match. A directed sequence sets this up: a small period, a shadow write mid-run, and then enough edges to cross the old period and then the new one. A long random run uses small periods and prescale ratios, toggles the timer clock densely and mixes in starts, stops, clears, captures and polarity flips. That way limit holds, one-shot stops, and collisions of a clear with a step or of a capture with a step occur many times. A reference model built from the requirements checks every cycle.

// File: rtl/ut_pkg.sv
package ut_pkg;
   // commands after the optional synchronizer
   typedef struct packed {
      logic start;
      logic stop;
      logic clr;
      logic capt;
      logic ext_lvl;
   } ut_cmd_t;

   localparam int unsigned CMD_W = $bits(ut_cmd_t);
endpackage

// File: rtl/ut_sync.sv
module ut_sync #(
   parameter int unsigned W  = 1,
   parameter bit          EN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (EN) begin : g_two_flop
         logic [W-1:0] s1, s2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1 <= '0;
               s2 <= '0;
            end else begin
               s1 <= d;
               s2 <= s1;
            end
         end
         assign q = s2;
      end else begin : g_bypass
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/ut_presc.sv
module ut_presc #(
   parameter int unsigned PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tclk_in,
   input  logic            rise_sel,
   input  logic [PS_W-1:0] psel,
   input  logic            hold,
   output logic            tedge,
   output logic            tick
);
   logic            tclk_q;
   logic [PS_W-1:0] pcnt;
   logic            at_top;

   assign tedge  = rise_sel ? (tclk_in & ~tclk_q) : (~tclk_in & tclk_q);
   assign at_top = (pcnt == psel);
   assign tick   = tedge & at_top & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tclk_q <= 1'b0;
         pcnt   <= '0;
      end else begin
         tclk_q <= tclk_in;
         if (hold)
            pcnt <= '0;
         else if (tedge)
            pcnt <= at_top ? '0 : pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/ut_capture.sv
module ut_capture #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capt,
   input  logic             ext_lvl,
   input  logic [CNT_W-1:0] live,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag,
   output logic             cap_evt
);
   logic ext_q;

   assign cap_evt = capt | (ext_lvl & ~ext_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q    <= 1'b0;
         cap_val  <= '0;
         cap_flag <= 1'b0;
      end else begin
         ext_q <= ext_lvl;
         if (cap_evt) begin
            cap_val  <= live;
            cap_flag <= 1'b1;
         end else if (flag_clr) begin
            cap_flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/univ_timer.sv
module univ_timer #(
   parameter int unsigned     CNT_W    = 16,
   parameter int unsigned     PS_W     = 8,
   parameter bit              SYNC_EN  = 1'b0,
   parameter logic [CNT_W-1:0] PER_INIT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tclk_in,
   input  logic             tclk_rise,
   input  logic [PS_W-1:0]  psel,
   input  logic             start,
   input  logic             stop,
   input  logic             oneshot_en,
   input  logic             wrap_en,
   input  logic             limit_en,
   input  logic             pulse_mode,
   input  logic             per_wr,
   input  logic [CNT_W-1:0] per_wdata,
   input  logic             ext_in,
   input  logic             ext_pol,
   input  logic             clr_cmd,
   input  logic             capt_cmd,
   input  logic [1:0]       flag_clr,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             run,
   output logic             tout,
   output logic             prd_flag,
   output logic             cap_flag
);
   import ut_pkg::*;

   localparam int unsigned ST_W = 2;

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt
         initial $fatal(1, "univ_timer: CNT_W out of range");
      end
      if (PS_W < 1 || PS_W > 16) begin : g_bad_ps
         initial $fatal(1, "univ_timer: PS_W out of range");
      end
   endgenerate

   ut_cmd_t          cmd_s;
   logic [CMD_W-1:0] cmd_bits;
   logic             c_start, c_stop, c_clr;
   logic             on_q, pls_q, tout_raw;
   logic [CNT_W-1:0] cnt_q, per_act, per_shd;
   logic             tedge, tick, match, load_start, cap_evt;

   ut_sync #(.W(CMD_W), .EN(SYNC_EN)) u_cmd_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({start, stop, clr_cmd, capt_cmd, ext_in ^ ext_pol}),
      .q     (cmd_bits)
   );
   assign cmd_s   = ut_cmd_t'(cmd_bits);
   assign c_start = cmd_s.start;
   assign c_stop  = cmd_s.stop;
   assign c_clr   = cmd_s.clr;

   ut_presc #(.PS_W(PS_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tclk_in  (tclk_in),
      .rise_sel (tclk_rise),
      .psel     (psel),
      .hold     (c_clr | ~on_q),
      .tedge    (tedge),
      .tick     (tick)
   );

   assign match      = tick & (cnt_q == per_act);
   assign load_start = c_start & ~on_q & ~c_stop;

   // count register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (c_clr)
         cnt_q <= '0;
      else if (match) begin
         if (wrap_en)
            cnt_q <= '0;
         else if (!limit_en)
            cnt_q <= cnt_q + 1'b1;
      end else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end

   // shadowed period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_shd <= PER_INIT;
         per_act <= PER_INIT;
      end else begin
         if (per_wr)
            per_shd <= per_wdata;
         if (load_start || (match && wrap_en))
            per_act <= per_shd;
      end
   end

   // run state, pulse output, period flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q     <= 1'b0;
         pls_q    <= 1'b0;
         prd_flag <= 1'b0;
      end else begin
         if (c_stop || (match && oneshot_en))
            on_q <= 1'b0;
         else if (c_start)
            on_q <= 1'b1;

         if (match)
            pls_q <= 1'b1;
         else if (tedge)
            pls_q <= 1'b0;

         if (match)
            prd_flag <= 1'b1;
         else if (flag_clr[0])
            prd_flag <= 1'b0;
      end
   end

   ut_capture #(.CNT_W(CNT_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .capt     (cmd_s.capt),
      .ext_lvl  (cmd_s.ext_lvl),
      .live     (cnt_q),
      .flag_clr (flag_clr[1]),
      .cap_val  (capture),
      .cap_flag (cap_flag),
      .cap_evt  (cap_evt)
   );

   assign tout_raw = pulse_mode ? pls_q : on_q;

   ut_sync #(.W(ST_W), .EN(SYNC_EN)) u_st_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({on_q, tout_raw}),
      .q     ({run, tout})
   );

   assign count = cnt_q;
endmodule

// File: rtl/ut_chk.sv
module ut_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             c_clr,
   input logic             c_stop,
   input logic             cap_evt,
   input logic             match,
   input logic             on_q,
   input logic             limit_en,
   input logic             wrap_en,
   input logic             oneshot_en,
   input logic             prd_flag,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] capture,
   input logic [CNT_W-1:0] per_act
);
   p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      c_clr |=> (count == '0));

   p_capt_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (capture == $past(count)));

   p_limit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_en && !wrap_en && count == per_act && !c_clr) |=> $stable(count));

   p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (match && oneshot_en) |=> !on_q);

   p_prd_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> prd_flag);

   p_stop_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      c_stop |=> !on_q);
endmodule

bind univ_timer ut_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .c_clr      (c_clr),
   .c_stop     (c_stop),
   .cap_evt    (cap_evt),
   .match      (match),
   .on_q       (on_q),
   .limit_en   (limit_en),
   .wrap_en    (wrap_en),
   .oneshot_en (oneshot_en),
   .prd_flag   (prd_flag),
   .count      (count),
   .capture    (capture),
   .per_act    (per_act)
);

// File: tb/univ_timer_tb.sv
module univ_timer_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tclk_in = 0, tclk_rise = 1, start = 0, stop = 0, oneshot_en = 0;
   logic wrap_en = 1, limit_en = 0, pulse_mode = 0, per_wr = 0;
   logic ext_in = 0, ext_pol = 0, clr_cmd = 0, capt_cmd = 0, s_start = 0;
   logic [7:0]  psel = 0;
   logic [15:0] per_wdata = 0;
   logic [1:0]  flag_clr = 0;
   logic [15:0] count, capture, s_count, s_capture;
   logic run, tout, prd_flag, cap_flag, s_run, s_tout, s_prd, s_cap;

   int total = 0, bad = 0;
   bit chk_en = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   univ_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .tclk_rise(tclk_rise), .psel(psel),
      .start(start), .stop(stop), .oneshot_en(oneshot_en), .wrap_en(wrap_en),
      .limit_en(limit_en), .pulse_mode(pulse_mode), .per_wr(per_wr), .per_wdata(per_wdata),
      .ext_in(ext_in), .ext_pol(ext_pol), .clr_cmd(clr_cmd), .capt_cmd(capt_cmd),
      .flag_clr(flag_clr), .count(count), .capture(capture), .run(run), .tout(tout),
      .prd_flag(prd_flag), .cap_flag(cap_flag));

   univ_timer #(.SYNC_EN(1'b1)) u_dut_sync (
      .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .tclk_rise(tclk_rise), .psel(psel),
      .start(s_start), .stop(1'b0), .oneshot_en(1'b0), .wrap_en(1'b1),
      .limit_en(1'b0), .pulse_mode(1'b0), .per_wr(1'b0), .per_wdata(16'd0),
      .ext_in(1'b0), .ext_pol(1'b0), .clr_cmd(1'b0), .capt_cmd(1'b0),
      .flag_clr(2'b00), .count(s_count), .capture(s_capture), .run(s_run), .tout(s_tout),
      .prd_flag(s_prd), .cap_flag(s_cap));

   task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model built from the requirements
   logic [15:0] m_cnt = 0, m_per = 16'hFFFF, m_shd = 16'hFFFF, m_cap = 0;
   logic [7:0]  m_pc = 0;
   logic m_on = 0, m_tq = 0, m_eq = 0, m_pls = 0, m_pf = 0, m_cf = 0;

   always @(posedge clk) begin
      logic edg, tck, mat, lvl, cev, ld;
      if (!rst_n) begin
         m_cnt = 0; m_per = 16'hFFFF; m_shd = 16'hFFFF; m_cap = 0; m_pc = 0;
         m_on = 0; m_tq = 0; m_eq = 0; m_pls = 0; m_pf = 0; m_cf = 0;
      end else begin
         edg = tclk_rise ? (tclk_in & !m_tq) : (!tclk_in & m_tq);
         tck = m_on & edg & (m_pc == psel) & !clr_cmd;
         mat = tck & (m_cnt == m_per);
         lvl = ext_in ^ ext_pol;
         cev = capt_cmd | (lvl & !m_eq);
         ld  = start & !m_on & !stop;
         if (cev) begin m_cap = m_cnt; m_cf = 1; end
         else if (flag_clr[1]) m_cf = 0;
         if (mat) m_pf = 1; else if (flag_clr[0]) m_pf = 0;
         if (mat) m_pls = 1; else if (edg) m_pls = 0;
         if (ld || (mat && wrap_en)) m_per = m_shd;
         if (per_wr) m_shd = per_wdata;
         if (clr_cmd) m_cnt = 0;
         else if (mat) begin
            if (wrap_en) m_cnt = 0;
            else if (!limit_en) m_cnt = m_cnt + 1;
         end else if (tck) m_cnt = m_cnt + 1;
         if (clr_cmd || !m_on) m_pc = 0;
         else if (edg) m_pc = (m_pc == psel) ? 8'd0 : m_pc + 1;
         if (stop || (mat && oneshot_en)) m_on = 0;
         else if (start) m_on = 1;
         m_tq = tclk_in;
         m_eq = lvl;
      end
   end

   always @(posedge clk) begin
      #1;
      if (chk_en) begin
         string cr;
         cr = wrap_en ? "R4" : (limit_en ? "R5" : "R6");
         check(cr, "count", count, m_cnt);
         check("R8", "capture", capture, m_cap);
         check(oneshot_en ? "R9" : "R12", "run", {15'd0, run}, {15'd0, m_on});
         check("R10", "tout", {15'd0, tout}, {15'd0, pulse_mode ? m_pls : m_on});
         check("R11", "prd_flag", {15'd0, prd_flag}, {15'd0, m_pf});
         check("R8", "cap_flag", {15'd0, cap_flag}, {15'd0, m_cf});
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tclk(int n);
      for (int i = 0; i < n; i++) begin
         tclk_in = 1; cyc(1);
         tclk_in = 0; cyc(1);
      end
   endtask

   task automatic halt_and_clear();
      stop = 1; clr_cmd = 1; flag_clr = 2'b11; cyc(1);
      stop = 0; clr_cmd = 0; flag_clr = 0; cyc(1);
   endtask

   task automatic set_period(logic [15:0] p);
      per_wr = 1; per_wdata = p; cyc(1);
      per_wr = 0; cyc(1);
   endtask

   task automatic go();
      start = 1; cyc(1);
      start = 0; cyc(1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      process::self().srandom(32'h5eed_1234);
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R13: reset state
      check("R13", "count", count, 16'd0);
      check("R13", "capture", capture, 16'd0);
      check("R13", "run/tout/flags", {12'd0, run, tout, prd_flag, cap_flag}, 16'd0);
      chk_en = 1;

      // R1: divide by 3
      tclk_rise = 1; psel = 2; wrap_en = 1; set_period(16'd100); go();
      pulse_tclk(9);
      check("R1", "count after 9 edges /3", count, 16'd3);

      // R2: falling edge selection
      halt_and_clear(); tclk_rise = 0; psel = 0; go();
      pulse_tclk(4);
      check("R2", "count after 4 falling edges", count, 16'd4);
      tclk_in = 1; cyc(2);
      check("R2", "rising edge ignored", count, 16'd4);
      tclk_in = 0; cyc(1);
      tclk_rise = 1; cyc(1);

      // R7: clear beats a step in the same cycle
      tclk_in = 1; clr_cmd = 1; cyc(1);
      clr_cmd = 0; tclk_in = 0; cyc(1);
      check("R7", "count after clear with edge", count, 16'd0);

      // R3: shadow period takes effect only at wrap
      halt_and_clear(); psel = 0; wrap_en = 1; limit_en = 0;
      set_period(16'd3); go();
      set_period(16'd5);
      pulse_tclk(4);
      check("R3", "wrap at old period", count, 16'd0);
      pulse_tclk(5);
      check("R3", "reach new period", count, 16'd5);

      // R14: synchronized start latency
      s_start = 1;
      for (int k = 1; k <= 5; k++) begin
         @(posedge clk); #2;
         s_start = 0;
         check("R14", "sync run", {15'd0, s_run}, {15'd0, k == 5});
      end
      cyc(1);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         start = 0; stop = 0; clr_cmd = 0; capt_cmd = 0; per_wr = 0; flag_clr = 0;
         if ($urandom_range(1, 0) == 1) tclk_in = ~tclk_in;
         if ($urandom_range(19, 0) == 0) start = 1;
         if ($urandom_range(79, 0) == 0) stop = 1;
         if ($urandom_range(59, 0) == 0) clr_cmd = 1;
         if ($urandom_range(29, 0) == 0) capt_cmd = 1;
         if ($urandom_range(14, 0) == 0) ext_in = ~ext_in;
         if ($urandom_range(199, 0) == 0) ext_pol = ~ext_pol;
         if ($urandom_range(9, 0) == 0) flag_clr = 2'($urandom_range(3, 1));
         if ($urandom_range(24, 0) == 0) begin
            per_wr = 1; per_wdata = 16'($urandom_range(12, 0));
         end
         if ($urandom_range(149, 0) == 0) begin
            oneshot_en = 1'($urandom_range(3, 0) == 0);
            wrap_en    = 1'($urandom_range(1, 0));
            limit_en   = 1'($urandom_range(1, 0));
            pulse_mode = 1'($urandom_range(1, 0));
            tclk_rise  = 1'($urandom_range(1, 0));
            psel       = 8'($urandom_range(3, 0));
         end
      end
      cyc(2);
      chk_en = 0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule